// File: doc/BRIEF.md
# Clock Generator Serial Configuration Slave

This block is the two-wire serial configuration port of a clock generator. It runs entirely on the system clock. It oversamples the serial clock and data lines, finds start and stop conditions and bit edges, and pulls the data line low through an open-drain enable when it acknowledges a byte or sends a zero bit. It keeps a bank of seven 8-bit configuration registers. Their contents appear on a flat parallel port. The controlling fields of register 0 are also decoded onto separate pins.

A host always writes as a block. After the write address it sends two bytes that the slave acknowledges and throws away. The data bytes that follow go to register 0, then register 1, and so on upward. A read starts with the register count and then returns every register from index 0 upward. No transfer can address a register at random. A repeated start abandons whatever transfer is in progress.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: An address byte of 0xD2 (7-bit address 0x69 with the R/W bit at 0) is acknowledged: the slave holds SDA low through the ninth SCL pulse.
- R2: Any other address byte, or any byte before the next start, gets no acknowledge and changes no register. While the slave is idle it never pulls SDA low.
- R3: In a write, the two bytes that follow the address are acknowledged and have no effect on any register.
- R4: Write data bytes, each sent MSB first, are acknowledged and stored in register 0, 1, 2 and onward in the order they arrive. A register changes only through such a store.
- R5: A stop after any complete byte ends the write. Registers the write did not reach keep their previous values.
- R6: Data bytes after the seventh one are acknowledged and discarded.
- R7: An address byte of 0xD3 is acknowledged. The slave then sends, MSB first, the count 7 followed by registers 0 through 6. Each bit changes only after a falling SCL edge. The slave goes on sending while the host acknowledges and releases SDA after a host non-acknowledge.
- R8: After reset, register 0 reads 0x00 and registers 1 to 6 read 0xFF.
- R9: The decoded pins follow register 0: bit 3 gives the register-driven frequency select, bits {2,6,5,4} give the 4-bit frequency code (bit 2 is the MSB), bit 1 gives spread enable, bit 7 gives wide spread depth, and bit 0 gives output disable.
- R10: A start condition in the middle of a byte aborts the transfer. The partial byte is not stored, and the next byte is taken as an address.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| cfg_regs_o | output | 56 | Register bank, register k in bits 8k+7:8k |
| freq_from_reg_o | output | 1 | Frequency taken from register code instead of latched pins |
| freq_code_o | output | 4 | Register-driven frequency code |
| spread_en_o | output | 1 | Center spread modulation enable |
| spread_deep_o | output | 1 | Wide spread depth select |
| outputs_off_o | output | 1 | Put all clock outputs in high impedance |

## Verification
The assertions assume the bus follows standard-mode timing relative to the system clock: SCL stays low and high for many system cycles, so the two-stage synchronizer always sees an edge before the host next moves SDA. They also assume the host never starts a new transfer while the slave is pulling SDA low. The bench's host tasks keep every SCL phase six or more cycles long and change SDA only in the middle of the low phase. Start and stop conditions are made only while the slave is released. Random block writes of 0 to 9 data bytes, with random command and count bytes, are each followed by a full read-back. Directed cases cover a foreign address, a short read and a repeated start in the middle of a byte.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;

    // byte index width; allows up to 13 registers after the two skipped bytes
    localparam int IDX_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RX     = 3'd1,
        ST_RX_ACK = 3'd2,
        ST_TX     = 3'd3,
        ST_TX_ACK = 3'd4
    } slv_state_e;

    typedef struct packed {
        slv_state_e       st;
        logic [3:0]       bitcnt;
        logic [7:0]       shreg;
        logic             is_addr;
        logic             is_read;
        logic             ack_ok;
        logic [IDX_W-1:0] idx;
        logic             sda_drv;
    } slv_regs_t;

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int W = SYNC_STAGES + 1;

    logic [W-1:0] scl_q, scl_d;
    logic [W-1:0] sda_q, sda_d;

    always_comb begin
        scl_d = {scl_q[W-2:0], scl_i};
        sda_d = {sda_q[W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    // stage SYNC_STAGES-1 is the synchronized level, stage SYNC_STAGES the previous one
    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = scl_q[SYNC_STAGES-1];
    assign scl_prev = scl_q[SYNC_STAGES];
    assign sda_now  = sda_q[SYNC_STAGES-1];
    assign sda_prev = sda_q[SYNC_STAGES];

    assign sda_s_o    = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev;
    assign scl_fall_o = ~scl_now & scl_prev;
    assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int NUM_REGS = 7,
    parameter int RIDX_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [RIDX_W-1:0]       wr_idx,
    input  logic [7:0]              wr_data,
    output logic [NUM_REGS*8-1:0]   regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] DFLT = (g == 0) ? 8'h00 : 8'hFF;
        logic [7:0] r_q, r_d;

        always_comb begin
            r_d = r_q;
            if (wr_en && (wr_idx == RIDX_W'(g))) r_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= DFLT;
            else        r_q <= r_d;
        end

        assign regs_o[g*8 +: 8] = r_q;
    end
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
    import cfg_slave_pkg::*;
#(
    parameter int         NUM_REGS  = 7,
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         SKIP_BYTES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_regs_o,
    output logic                  freq_from_reg_o,
    output logic [3:0]            freq_code_o,
    output logic                  spread_en_o,
    output logic                  spread_deep_o,
    output logic                  outputs_off_o
);
    localparam int               RIDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [IDX_W-1:0] SKIP_L = IDX_W'(SKIP_BYTES);
    localparam logic [IDX_W-1:0] NUM_L  = IDX_W'(NUM_REGS);
    localparam logic [7:0]       COUNT_BYTE = 8'(NUM_REGS);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    cfg_line_sync #(.SYNC_STAGES(2)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    slv_regs_t         q, d;
    logic              bank_wr_en;
    logic [RIDX_W-1:0] bank_wr_idx;
    logic [IDX_W-1:0]  tx_sel;
    logic [7:0]        tx_byte;
    logic              bus_idle;

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .RIDX_W(RIDX_W)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr_en),
        .wr_idx  (bank_wr_idx),
        .wr_data (q.shreg),
        .regs_o  (cfg_regs_o)
    );

    // transmit byte: index 0 is the count, index k is register k-1
    always_comb begin
        tx_sel  = (q.st == ST_RX_ACK) ? '0 : q.idx;
        tx_byte = 8'hFF;
        if (tx_sel == '0) tx_byte = COUNT_BYTE;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (tx_sel == IDX_W'(i + 1)) tx_byte = cfg_regs_o[i*8 +: 8];
        end
    end

    always_comb begin
        d           = q;
        bank_wr_en  = 1'b0;
        bank_wr_idx = '0;
        if (start_det) begin
            d.st      = ST_RX;
            d.bitcnt  = '0;
            d.is_addr = 1'b1;
            d.is_read = 1'b0;
            d.idx     = '0;
            d.sda_drv = 1'b0;
        end else if (stop_det) begin
            d.st      = ST_IDLE;
            d.sda_drv = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        if (q.is_addr) begin
                            if (q.shreg[7:1] == DEV_ADDR) begin
                                d.is_read = q.shreg[0];
                                d.sda_drv = 1'b1;
                                d.st      = ST_RX_ACK;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.sda_drv = 1'b1;
                            d.st      = ST_RX_ACK;
                            if (q.idx >= SKIP_L && q.idx < SKIP_L + NUM_L) begin
                                bank_wr_en  = 1'b1;
                                bank_wr_idx = RIDX_W'(q.idx - SKIP_L);
                            end
                            if (q.idx != '1) d.idx = q.idx + 1'b1;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.sda_drv = 1'b0;
                        d.bitcnt  = '0;
                        d.is_addr = 1'b0;
                        if (q.is_addr && q.is_read) begin
                            d.st      = ST_TX;
                            d.shreg   = tx_byte;
                            d.sda_drv = ~tx_byte[7];
                            d.idx     = IDX_W'(1);
                        end else begin
                            d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.sda_drv = 1'b0;
                            d.st      = ST_TX_ACK;
                        end else begin
                            d.shreg   = {q.shreg[6:0], 1'b0};
                            d.sda_drv = ~q.shreg[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.ack_ok = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.ack_ok) begin
                            d.st      = ST_TX;
                            d.bitcnt  = '0;
                            d.shreg   = tx_byte;
                            d.sda_drv = ~tx_byte[7];
                            if (q.idx != '1) d.idx = q.idx + 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_idle        = (q.st == ST_IDLE);
    assign sda_oe_o        = q.sda_drv;
    assign freq_from_reg_o = cfg_regs_o[3];
    assign freq_code_o     = {cfg_regs_o[2], cfg_regs_o[6:4]};
    assign spread_en_o     = cfg_regs_o[1];
    assign spread_deep_o   = cfg_regs_o[7];
    assign outputs_off_o   = cfg_regs_o[0];
endmodule

// File: rtl/cfg_slave_chk.sv
module cfg_slave_chk #(
    parameter int NUM_REGS = 7,
    parameter int RIDX_W   = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] cfg_regs_o,
    input logic                  wr_en,
    input logic [RIDX_W-1:0]     wr_idx,
    input logic                  idle_q
);
    localparam logic [NUM_REGS*8-1:0] DFLT = {{(NUM_REGS-1){8'hFF}}, 8'h00};

    // R11
    sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R4
    reg_change_by_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_regs_o) |-> $past(wr_en));

    // R6
    store_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_REGS));

    // R2
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q |-> !sda_oe_o);

    // R8
    reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_regs_o == DFLT));
endmodule

bind clkgen_cfg_slave cfg_slave_chk #(.NUM_REGS(NUM_REGS), .RIDX_W(RIDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .cfg_regs_o (cfg_regs_o),
    .wr_en      (bank_wr_en),
    .wr_idx     (bank_wr_idx),
    .idle_q     (bus_idle)
);

// File: tb/clkgen_cfg_slave_tb.sv
module clkgen_cfg_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 7;
    localparam int QW = 6;   // quarter bit, system cycles
    localparam int HW = 12;  // SCL high time

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [NREG*8-1:0] regs;
    logic freq_from_reg, spread_en, spread_deep, outputs_off;
    logic [3:0] freq_code;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_cfg_slave dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_bus),
        .sda_oe_o        (sda_oe),
        .cfg_regs_o      (regs),
        .freq_from_reg_o (freq_from_reg),
        .freq_code_o     (freq_code),
        .spread_en_o     (spread_en),
        .spread_deep_o   (spread_deep),
        .outputs_off_o   (outputs_off)
    );

    int n_tests = 0;
    int n_fail = 0;
    int scl_viol = 0;
    bit done = 0;
    logic [7:0] exp_reg [NREG];
    logic [7:0] wbuf [12];
    logic prev_oe = 1'b0;

    // R11 monitor: drive changes seen while SCL is high
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== prev_oe && scl_m) scl_viol++;
        end
        prev_oe = sda_oe;
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NREG*8-1:0] exp_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = exp_reg[i];
        return f;
    endfunction

    function automatic logic [7:0] exp_fields();
        logic [7:0] r;
        r = exp_reg[0];
        return {r[3], r[2], r[6:4], r[1], r[7], r[0]};
    endfunction

    task automatic start_cond();
        sda_m = 1'b1; wc(QW);
        scl_m = 1'b1; wc(QW);
        sda_m = 1'b0; wc(QW);
        scl_m = 1'b0; wc(QW);
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; wc(QW);
        scl_m = 1'b1; wc(QW);
        sda_m = 1'b1; wc(QW);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wc(QW);
        scl_m = 1'b1; wc(HW);
        scl_m = 1'b0; wc(QW);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; wc(QW);
        scl_m = 1'b1; wc(HW/2);
        acked = ~sda_bus; wc(HW/2);
        scl_m = 1'b0; wc(QW);
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wc(QW);
            scl_m = 1'b1; wc(HW/2);
            b = {b[6:0], sda_bus}; wc(HW/2);
            scl_m = 1'b0; wc(QW);
        end
        sda_m = ~host_ack; wc(QW);
        scl_m = 1'b1; wc(HW);
        scl_m = 1'b0; wc(QW);
        sda_m = 1'b1;
    endtask

    // block write of n data bytes from wbuf
    task automatic do_write(input int n);
        logic a;
        start_cond();
        send_byte(8'hD2, a);
        chk(a, "R1 write address ack", a, 1);
        send_byte(8'($urandom), a);
        chk(a, "R3 command byte ack", a, 1);
        send_byte(8'($urandom), a);
        chk(a, "R3 count byte ack", a, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            chk(a, (k < NREG) ? "R4 data byte ack" : "R6 extra byte ack", a, 1);
            if (k < NREG) exp_reg[k] = wbuf[k];
        end
        stop_cond();
        wc(4);
        chk(regs == exp_flat(), "R5 register bank after write", regs, exp_flat());
    endtask

    // read count plus nbytes registers, host NACKs the last byte
    task automatic do_read(input int nbytes);
        logic a;
        logic [7:0] b;
        start_cond();
        send_byte(8'hD3, a);
        chk(a, "R7 read address ack", a, 1);
        recv_byte(nbytes > 0, b);
        chk(b == 8'd7, "R7 byte count", b, 7);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(k < nbytes - 1, b);
            chk(b == exp_reg[k], "R7 read-back register", b, exp_reg[k]);
        end
        wc(2);
        chk(!sda_oe, "R7 release after host nack", sda_oe, 0);
        stop_cond();
        wc(4);
    endtask

    task automatic check_fields();
        logic [7:0] act;
        act = {freq_from_reg, freq_code, spread_en, spread_deep, outputs_off};
        chk(act == exp_fields(), "R9 decoded fields", act, exp_fields());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] b;
        void'($urandom(32'd4242));
        exp_reg[0] = 8'h00;
        for (int i = 1; i < NREG; i++) exp_reg[i] = 8'hFF;
        wc(5);
        rst_n = 1'b1;
        wc(5);

        // R8 reset values
        chk(regs == exp_flat(), "R8 reset defaults", regs, exp_flat());
        chk(!sda_oe, "R2 idle releases SDA", sda_oe, 0);
        check_fields();

        // R8 read-back of defaults
        do_read(NREG);

        // R4 R5 short write of three bytes
        wbuf[0] = 8'hBA; wbuf[1] = 8'h12; wbuf[2] = 8'h34;
        do_write(3);
        check_fields();
        do_read(NREG);

        // R6 full write plus two extra bytes
        for (int k = 0; k < 9; k++) wbuf[k] = 8'(8'h40 + k * 8'h11);
        do_write(9);
        check_fields();
        do_read(NREG);

        // R2 foreign address: no ack, later bytes ignored
        start_cond();
        send_byte(8'hA4, a);
        chk(!a, "R2 foreign address nack", a, 0);
        send_byte(8'h55, a);
        chk(!a, "R2 byte after foreign address nack", a, 0);
        send_byte(8'h66, a);
        chk(!a, "R2 second byte ignored", a, 0);
        stop_cond();
        wc(4);
        chk(regs == exp_flat(), "R2 registers untouched", regs, exp_flat());

        // R7 short read: host stops after two registers
        do_read(2);

        // R10 repeated start in the middle of a data byte
        start_cond();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'hA5, a);
        exp_reg[0] = 8'hA5;
        bit_out(1'b0); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        start_cond();
        send_byte(8'hD3, a);
        chk(a, "R10 address after repeated start", a, 1);
        recv_byte(1'b1, b);
        chk(b == 8'd7, "R10 count after repeated start", b, 7);
        recv_byte(1'b1, b);
        chk(b == exp_reg[0], "R10 completed byte kept", b, exp_reg[0]);
        recv_byte(1'b0, b);
        chk(b == exp_reg[1], "R10 partial byte discarded", b, exp_reg[1]);
        stop_cond();
        wc(4);
        chk(regs == exp_flat(), "R10 bank after abort", regs, exp_flat());

        // random block writes, each read back
        for (int it = 0; it < 12; it++) begin
            int n;
            n = int'($urandom_range(0, 9));
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(n);
            check_fields();
            do_read(NREG);
        end

        chk(scl_viol == 0, "R11 SDA drive changes only with SCL low", scl_viol, 0);
        finish_run();
    end
endmodule